// File: doc/BRIEF.md
# Power-Up Serial Configuration Sequencer

This block sends one 12-bit configuration word to an external device over a three-wire link after every reset. The link has a serial clock, a data line and a framing strobe. The strobe goes low to open the frame. Twelve serial clock pulses then move the word out, most-significant bit first, and the receiver samples data on each falling clock edge. The strobe returns high to commit the word. After that the block raises a done flag and holds every output still until the next reset.

The word has fixed control bits placed around a 6-bit delay field. The low three bits of that field come from a 3-bit switch input, which selects one of eight delay settings. The block reads the switch once, in the cycle that opens the frame. A programmable divider sets the serial clock half-period in system clocks. The divider stops when the done flag rises.

Top module: `scfg_sequencer`

## Requirements
- R1: Each reset produces exactly one frame. After `done_o` rises it stays high, and `sck_o`, `data_o` and `req_o` hold their values until the next reset.
- R2: While `rst_ni` is low: `sck_o` = 1, `req_o` = 1, `data_o` = 0 and `done_o` = 0. While `req_o` is high, `sck_o` is high.
- R3: While `req_o` is low, `sck_o` falls exactly 12 times. No `sck_o` falling edge occurs while `req_o` is high.
- R4: `data_o` changes only with a rising `sck_o` edge or with the falling `req_o` edge that presents the first bit. It is therefore stable at every falling `sck_o` edge.
- R5: The bits on the 12 falling edges are, in order: sleep = 0, the six delay-field bits, mute = 0, then four identification bits 0, 0, 1, 1.
- R6: The delay field is sent MSB first. Its upper three bits are 0 and its lower three bits are `sw_i` (value n selects a delay of (n+1) × 0.5 ms).
- R7: `sw_i` is captured in the cycle `req_o` falls. A change of `sw_i` after that point does not alter any transmitted bit.
- R8: The `sck_o` half-period is HALF_DIV system clocks. The first `sck_o` fall comes HALF_DIV clocks after `req_o` falls, and `req_o` rises HALF_DIV clocks after the twelfth `sck_o` rise.
- R9: `done_o` rises 2×HALF_DIV system clocks (one serial clock period) after `req_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sw_i | input | 3 | Delay selection switches |
| sck_o | output | 1 | Serial clock, idles high |
| data_o | output | 1 | Serial data, sampled by the receiver on falling `sck_o` |
| req_o | output | 1 | Frame strobe, low during the frame, rising edge commits |
| done_o | output | 1 | Sticky completion flag |

## Verification
A wrong bit counter shows up at once as a falling-edge count other than twelve when the strobe rises, or as a shifted word in which the identification pair 1,1 lands somewhere other than the last two sampled bits. If the shifter loads at the wrong moment, the word follows the switch value at the wrong time, so a switch change made mid-frame leaks into the sampled bits. A divider or tail-count fault appears within one serial period, as a gap between the strobe, the clock and the done flag that differs from HALF_DIV. A sequencer that does not stop shows up as output activity after the done flag.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int unsigned SW_W       = 3;
  localparam int unsigned DLY_W      = 6;
  localparam int unsigned ID_W       = 4;
  localparam int unsigned FRAME_BITS = 1 + DLY_W + 1 + ID_W;

  localparam logic [ID_W-1:0] ID_CODE = 4'b0011;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_FRAME,
    ST_CLOSE,
    ST_TAIL,
    ST_DONE
  } seq_state_e;

  // MSB goes out first: sleep, delay field, mute, id bits
  function automatic logic [FRAME_BITS-1:0] build_word(input logic [SW_W-1:0] sw);
    logic [DLY_W-1:0] dly;
    dly = {{(DLY_W-SW_W){1'b0}}, sw};
    return {1'b0, dly, 1'b0, ID_CODE};
  endfunction
endpackage

// File: rtl/scfg_tick_gen.sv
module scfg_tick_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scfg_shift_reg.sv
module scfg_shift_reg
  import scfg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [SW_W-1:0] sw_i,
  output logic            data_o
);
  logic [FRAME_BITS-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= build_word(sw_i);
    end else if (shift_i) begin
      word_q <= {word_q[FRAME_BITS-2:0], word_q[FRAME_BITS-1]};
    end
  end

  assign data_o = word_q[FRAME_BITS-1];
endmodule

// File: rtl/scfg_frame_fsm.sv
module scfg_frame_fsm
  import scfg_pkg::*;
#(
  parameter int unsigned START_TICKS = 2,
  parameter int unsigned TAIL_TICKS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic load_o,
  output logic shift_o,
  output logic sck_o,
  output logic req_o,
  output logic done_o
);
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam int unsigned WW = (START_TICKS > 1) ? $clog2(START_TICKS) : 1;
  localparam int unsigned TW = (TAIL_TICKS > 1) ? $clog2(TAIL_TICKS) : 1;
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(START_TICKS - 1);
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_TICKS - 1);

  seq_state_e state_q;
  logic [BW-1:0] bit_q;
  logic [WW-1:0] wait_q;
  logic [TW-1:0] tail_q;
  logic sck_q, req_q, done_q;

  assign load_o  = tick_i && (state_q == ST_WAIT) && (wait_q == WAIT_LAST);
  assign shift_o = tick_i && (state_q == ST_FRAME) && !sck_q && (bit_q != BIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      bit_q   <= '0;
      wait_q  <= '0;
      tail_q  <= '0;
      sck_q   <= 1'b1;
      req_q   <= 1'b1;
      done_q  <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_WAIT: begin
          if (wait_q == WAIT_LAST) begin
            req_q   <= 1'b0;
            state_q <= ST_FRAME;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_FRAME: begin
          if (sck_q) begin
            sck_q <= 1'b0;
          end else begin
            sck_q <= 1'b1;
            if (bit_q == BIT_LAST) state_q <= ST_CLOSE;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        ST_CLOSE: begin
          req_q   <= 1'b1;
          state_q <= ST_TAIL;
        end
        ST_TAIL: begin
          if (tail_q == TAIL_LAST) begin
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            tail_q <= tail_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign req_o  = req_q;
  assign done_o = done_q;
endmodule

// File: rtl/scfg_sequencer.sv
module scfg_sequencer
  import scfg_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned START_TICKS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW_W-1:0] sw_i,
  output logic            sck_o,
  output logic            data_o,
  output logic            req_o,
  output logic            done_o
);
  logic tick, load, shift, done;

  scfg_tick_gen #(.HALF_DIV(HALF_DIV)) tick_gen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!done),
    .tick_o (tick)
  );

  scfg_frame_fsm #(.START_TICKS(START_TICKS), .TAIL_TICKS(2)) fsm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .load_o  (load),
    .shift_o (shift),
    .sck_o   (sck_o),
    .req_o   (req_o),
    .done_o  (done)
  );

  scfg_shift_reg shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .sw_i    (sw_i),
    .data_o  (data_o)
  );

  assign done_o = done;
endmodule

// File: rtl/scfg_sequencer_chk.sv
module scfg_sequencer_chk
  import scfg_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic data_o,
  input logic req_o,
  input logic done_o
);
  logic       sck_d;
  logic [4:0] fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b1;
      fall_cnt <= '0;
    end else begin
      sck_d <= sck_o;
      if (sck_d && !sck_o && fall_cnt != 5'h1f) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assert_idle_sck_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> sck_o);
  assert_fall_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> !req_o);
  assert_fall_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (fall_cnt == 5'(FRAME_BITS)));
  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> $stable(data_o));
  assert_data_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> ($rose(sck_o) || $fell(req_o)));
  assert_done_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_static_after_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable({sck_o, data_o, req_o}));
  assert_done_after_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> req_o);
endmodule

bind scfg_sequencer scfg_sequencer_chk chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sck_o  (sck_o),
  .data_o (data_o),
  .req_o  (req_o),
  .done_o (done_o)
);

// File: tb/scfg_sequencer_tb_top.sv
`timescale 1ns/1ps
module scfg_sequencer_tb_top;
  localparam int HALF_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sw = 3'd0;
  logic       sck, data, req, done;

  always #2 clk = ~clk;

  scfg_sequencer #(.HALF_DIV(HALF_DIV), .START_TICKS(2)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sw_i   (sw),
    .sck_o  (sck),
    .data_o (data),
    .req_o  (req),
    .done_o (done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_q[$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // monitor state
  int  cyc = 0;
  bit  p_sck, p_req, p_data, p_done;
  int  req_fall_cyc, req_rise_cyc, last_rise_cyc;
  int  falls, rises;
  logic [11:0] rx_word;
  bit  first_fall;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_sck = sck; p_req = req; p_data = data; p_done = done;
      falls = 0; rises = 0; rx_word = '0; first_fall = 1'b1;
    end else begin
      if (p_req && !req) req_fall_cyc = cyc;
      if (p_sck && !sck) begin
        falls++;
        check(!req, "R3", int'(req), 0);
        check(data == p_data, "R4", int'(data), int'(p_data));
        if (first_fall) begin
          check(cyc - req_fall_cyc == HALF_DIV, "R8", cyc - req_fall_cyc, HALF_DIV);
          first_fall = 1'b0;
        end
        rx_word = {rx_word[10:0], data};
        if (exp_q.size() == 0) check(1'b0, "R5", falls, 12);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(data == e, "R5", int'(data), int'(e));
        end
      end
      if (!p_sck && sck) begin
        rises++;
        last_rise_cyc = cyc;
      end
      if (data != p_data)
        check((!p_sck && sck) || (p_req && !req), "R4", int'(data), int'(p_data));
      if (!p_req && req) begin
        req_rise_cyc = cyc;
        check(falls == 12, "R3", falls, 12);
        check(cyc - last_rise_cyc == HALF_DIV, "R8", cyc - last_rise_cyc, HALF_DIV);
      end
      if (!p_done && done)
        check(cyc - req_rise_cyc == 2 * HALF_DIV, "R9", cyc - req_rise_cyc, 2 * HALF_DIV);
      if (p_done)
        check(done && sck == p_sck && req == p_req && data == p_data, "R1",
              int'({done, sck, req, data}), int'({1'b1, p_sck, p_req, p_data}));
      p_sck = sck; p_req = req; p_data = data; p_done = done;
    end
  end

  task automatic run_case(input logic [2:0] sw0, input bit mid, input logic [2:0] sw1);
    logic [11:0] w;
    rst_n = 1'b0;
    sw = sw0;
    w = {1'b0, 3'b000, sw0, 1'b0, 4'b0011};
    exp_q.delete();
    for (int i = 11; i >= 0; i--) exp_q.push_back(w[i]);
    repeat (3) @(negedge clk);
    check(sck === 1'b1 && req === 1'b1 && data === 1'b0 && done === 1'b0, "R2",
          int'({sck, req, data, done}), 4'b1100);
    rst_n = 1'b1;
    if (mid) begin
      wait (req == 1'b0);
      repeat (2) @(negedge clk);
      sw = sw1;
    end
    wait (done == 1'b1);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    check(rx_word == w, mid ? "R7" : "R6", int'(rx_word), int'(w));
    check(done == 1'b1 && falls == 12 && rises == 12, "R1", falls, 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    run_case(3'd0, 1'b0, 3'd0);
    run_case(3'd5, 1'b0, 3'd0);
    run_case(3'd7, 1'b0, 3'd0);
    run_case(3'd2, 1'b1, 3'd5);
    run_case(3'd6, 1'b1, 3'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule